// File: doc/BRIEF.md
# Standby Mode Sequencer

This block sequences a small CPU core in and out of two low-power states. A halt request from the instruction decoder puts the core into a light standby. In that state only the CPU is frozen: the oscillator and the peripheral clocks keep running, and the free-running timer runs unless the software has made it irrelevant. A deep-sleep request, which is honoured only when the condition-code stop mask is clear, gates every clock, the oscillator enable included.

Leaving either state produces a one-cycle wake action. The core either resumes at the next instruction, begins interrupt stacking, or runs its reset sequence. The choice depends on which wake source fired and on the state of the interrupt mask bits. The non-maskable interrupt line wakes the core from deep sleep even when it is masked, but the core then simply resumes and no interrupt is taken. When the block leaves deep sleep it can hold the clocks off for an oscillator-settle interval. A configuration bit can waive that interval, but any reset forces the bit back on, and the interval is always counted after power-on.

The external pins (maskable interrupt, non-maskable interrupt, reset) are asynchronous active-low levels and pass through a two-stage synchronizer. When several pins are asserted together, reset wins over the non-maskable line, and the non-maskable line wins over the maskable one.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A deep-sleep request while `mask_s` is 1 has no effect: `mode` stays RUN (0) and all clocks stay enabled.
- R2: A deep-sleep request while `mask_s` is 0 enters STOP (`mode`=2). In STOP, `osc_en`, `periph_clk_en` and `timer_clk_en` are all 0, and `cpu_halt` is 1.
- R3: A halt request enters WAIT (`mode`=1) with `cpu_halt`=1, `osc_en`=1 and `periph_clk_en`=1. In WAIT, `timer_clk_en` is 0 only when both `mask_i` and `nocop` are 1.
- R4: WAIT ends with wake code SERVICE (2) on any unmasked interrupt: the maskable pin or the pending-edge flag or an internal request when `mask_i` is 0, or the non-maskable pin when `mask_x` is 0. Masked sources leave the block in WAIT.
- R5: STOP ends on the maskable pin or the pending-edge flag only when `mask_i` is 0. Internal peripheral requests never end STOP.
- R6: The non-maskable pin ends STOP whatever `mask_x` is. The wake code is SERVICE (2) when `mask_x` is 0 and RESUME (1) when it is 1.
- R7: When several wake sources are active together, the wake code follows reset first, then the non-maskable pin, then the maskable pin.
- R8: When the settle bit is 1, leaving STOP passes through SETTLE (`mode`=3) for exactly `SETTLE_CYCLES` cycles, with `osc_en`=1, `cpu_halt`=1 and `periph_clk_en`=0. When the bit is 0 and the wake source is not reset, the block goes straight to RUN.
- R9: Any reset, whether power-on or the reset pin, sets the settle bit `dly` to 1. After power-on the block counts SETTLE and then emits wake code RESET (3). Leaving STOP through the reset pin also counts SETTLE.
- R10: A reset pin assertion in RUN or WAIT emits wake code RESET (3) and lands in RUN without a settle interval.
- R11: `wake_valid` is high for one cycle per wake. `wake_code` is NONE (0) whenever `wake_valid` is 0.
- R12: While `rst_n` is low: `mode`=3, `osc_en`=1, `cpu_halt`=1, `dly`=1 and `wake_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wait_req | input | 1 | Halt request pulse from the decoder |
| stop_req | input | 1 | Deep-sleep request pulse from the decoder |
| mask_s | input | 1 | Stop-disable mask bit |
| mask_x | input | 1 | Non-maskable-interrupt mask bit |
| mask_i | input | 1 | Maskable-interrupt mask bit |
| nocop | input | 1 | Watchdog-disabled configuration bit |
| dly_wr | input | 1 | Write strobe for the settle bit |
| dly_wr_val | input | 1 | Value written to the settle bit |
| irq_n | input | 1 | Maskable interrupt pin, asynchronous, active low |
| xirq_n | input | 1 | Non-maskable interrupt pin, asynchronous, active low |
| ext_reset_n | input | 1 | Reset pin, asynchronous, active low |
| irq_edge_pend | input | 1 | Latched pending edge on the maskable interrupt |
| int_req | input | 1 | Any internal peripheral interrupt request |
| cpu_halt | output | 1 | Freeze the CPU |
| periph_clk_en | output | 1 | Peripheral clock gate |
| osc_en | output | 1 | Oscillator enable |
| timer_clk_en | output | 1 | Free-running timer clock gate |
| wake_valid | output | 1 | One-cycle wake strobe |
| wake_code | output | 2 | 0 none, 1 resume, 2 service interrupt, 3 reset sequence |
| mode | output | 2 | 0 RUN, 1 WAIT, 2 STOP, 3 SETTLE |
| dly | output | 1 | Current settle bit |

## Verification
The bench targets the masked non-maskable line in both standby states. A design that ignored the mask would wrongly end WAIT, and one that honoured the mask in STOP would never wake, or would report SERVICE where RESUME is due. It checks that internal requests cannot end deep sleep and that the stop mask turns a deep-sleep request into a no-op. It also combines the reset pin with a cleared settle bit: a design that kept the cleared bit would skip the settle interval. The exact length of SETTLE and the RESUME-over-SERVICE outcome when the masked non-maskable pin and an unmasked maskable pin fire together catch off-by-one counters and inverted priority.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_WAIT   = 2'd1,
    MODE_STOP   = 2'd2,
    MODE_SETTLE = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    WK_NONE    = 2'd0,
    WK_RESUME  = 2'd1,
    WK_SERVICE = 2'd2,
    WK_RESET   = 2'd3
  } wake_e;
endpackage

// File: rtl/pwr_sync_bits.sv
module pwr_sync_bits #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int SETTLE_CYCLES = 4064
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!done) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb
  import pwr_mode_pkg::*;
(
  input  logic  in_stop,
  input  logic  rst_lvl,
  input  logic  xirq_lvl,
  input  logic  irq_lvl,
  input  logic  irq_edge_pend,
  input  logic  int_req,
  input  logic  mask_x,
  input  logic  mask_i,
  output logic  hit,
  output wake_e code
);
  logic irq_ok, xirq_ok, intr_ok;

  always_comb begin
    irq_ok  = (irq_lvl || irq_edge_pend) && !mask_i;
    // deep sleep: non-maskable pin wakes regardless of its mask
    xirq_ok = in_stop ? xirq_lvl : (xirq_lvl && !mask_x);
    // internal sources have no clock in deep sleep
    intr_ok = !in_stop && int_req && !mask_i;

    hit  = 1'b1;
    code = WK_SERVICE;
    if (rst_lvl) begin
      code = WK_RESET;
    end else if (xirq_ok) begin
      code = (in_stop && mask_x) ? WK_RESUME : WK_SERVICE;
    end else if (irq_ok || intr_ok) begin
      code = WK_SERVICE;
    end else begin
      hit  = 1'b0;
      code = WK_NONE;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4064,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_req,
  input  logic       stop_req,
  input  logic       mask_s,
  input  logic       mask_x,
  input  logic       mask_i,
  input  logic       nocop,
  input  logic       dly_wr,
  input  logic       dly_wr_val,
  input  logic       irq_n,
  input  logic       xirq_n,
  input  logic       ext_reset_n,
  input  logic       irq_edge_pend,
  input  logic       int_req,
  output logic       cpu_halt,
  output logic       periph_clk_en,
  output logic       osc_en,
  output logic       timer_clk_en,
  output logic       wake_valid,
  output logic [1:0] wake_code,
  output logic [1:0] mode,
  output logic       dly
);
  localparam int PINS = 3;

  // reset: asynchronous assertion, synchronous release
  logic rst_sync_n;
  pwr_sync_bits #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  // pin synchronizers (idle level is high)
  logic [PINS-1:0] pins_s;
  pwr_sync_bits #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL({PINS{1'b1}})) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({ext_reset_n, xirq_n, irq_n}),
    .q     (pins_s)
  );

  logic rst_lvl, xirq_lvl, irq_lvl;
  assign irq_lvl  = ~pins_s[0];
  assign xirq_lvl = ~pins_s[1];
  assign rst_lvl  = ~pins_s[2];

  mode_e state_q, state_d;
  wake_e pend_q, pend_d;
  wake_e code_q, code_d;
  logic  vld_q, vld_d;
  logic  dly_q, dly_d;
  logic  rst_prev_q;
  logic  state_en, pend_en, dly_en;

  logic  arb_hit;
  wake_e arb_code;
  pwr_wake_arb u_arb (
    .in_stop       (state_q == MODE_STOP),
    .rst_lvl       (rst_lvl),
    .xirq_lvl      (xirq_lvl),
    .irq_lvl       (irq_lvl),
    .irq_edge_pend (irq_edge_pend),
    .int_req       (int_req),
    .mask_x        (mask_x),
    .mask_i        (mask_i),
    .hit           (arb_hit),
    .code          (arb_code)
  );

  logic settle_done;
  pwr_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (state_q == MODE_SETTLE),
    .done  (settle_done)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    vld_d   = 1'b0;
    code_d  = WK_NONE;

    dly_d = dly_q;
    if (dly_wr) dly_d = dly_wr_val;
    if (rst_lvl) dly_d = 1'b1;

    unique case (state_q)
      MODE_RUN: begin
        if (rst_lvl && !rst_prev_q) begin
          vld_d  = 1'b1;
          code_d = WK_RESET;
        end else if (stop_req) begin
          if (!mask_s) state_d = MODE_STOP;
        end else if (wait_req) begin
          state_d = MODE_WAIT;
        end
      end
      MODE_WAIT: begin
        if (arb_hit) begin
          state_d = MODE_RUN;
          vld_d   = 1'b1;
          code_d  = arb_code;
        end
      end
      MODE_STOP: begin
        if (arb_hit) begin
          if (arb_code == WK_RESET || dly_q) begin
            state_d = MODE_SETTLE;
            pend_d  = arb_code;
          end else begin
            state_d = MODE_RUN;
            vld_d   = 1'b1;
            code_d  = arb_code;
          end
        end
      end
      MODE_SETTLE: begin
        if (rst_lvl) pend_d = WK_RESET;
        if (settle_done) begin
          state_d = MODE_RUN;
          vld_d   = 1'b1;
          code_d  = rst_lvl ? WK_RESET : pend_q;
        end
      end
      default: state_d = MODE_RUN;
    endcase
  end

  assign state_en = (state_d != state_q);
  assign pend_en  = (pend_d != pend_q);
  assign dly_en   = (dly_d != dly_q);

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= MODE_SETTLE;
      pend_q     <= WK_RESET;
      vld_q      <= 1'b0;
      code_q     <= WK_NONE;
      dly_q      <= 1'b1;
      rst_prev_q <= 1'b0;
    end else begin
      if (state_en) state_q <= state_d;
      if (pend_en)  pend_q  <= pend_d;
      if (dly_en)   dly_q   <= dly_d;
      vld_q      <= vld_d;
      code_q     <= code_d;
      rst_prev_q <= rst_lvl;
    end
  end

  // clock-gate decode
  always_comb begin
    cpu_halt      = 1'b1;
    periph_clk_en = 1'b0;
    osc_en        = 1'b1;
    timer_clk_en  = 1'b0;
    unique case (state_q)
      MODE_RUN: begin
        cpu_halt      = 1'b0;
        periph_clk_en = 1'b1;
        timer_clk_en  = 1'b1;
      end
      MODE_WAIT: begin
        periph_clk_en = 1'b1;
        timer_clk_en  = !(mask_i && nocop);
      end
      MODE_STOP: begin
        osc_en = 1'b0;
      end
      default: ;
    endcase
  end

  assign wake_valid = vld_q;
  assign wake_code  = code_q;
  assign mode       = state_q;
  assign dly        = dly_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_req,
  input logic       mask_s,
  input logic       mask_i,
  input logic       nocop,
  input logic       cpu_halt,
  input logic       periph_clk_en,
  input logic       osc_en,
  input logic       timer_clk_en,
  input logic       wake_valid,
  input logic [1:0] wake_code,
  input logic [1:0] mode
);
  AST_MASKED_STOP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && stop_req && mask_s) |=> (mode != 2'd2)); // R1

  AST_STOP_ENTRY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) == 2'd0) |-> (!$past(mask_s) && $past(stop_req))); // R2

  AST_STOP_ALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!osc_en && !periph_clk_en && !timer_clk_en && cpu_halt)); // R2

  AST_WAIT_TIMER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && mask_i && nocop) |-> !timer_clk_en); // R3

  AST_SETTLE_OSC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (osc_en && cpu_halt && !periph_clk_en)); // R8

  AST_RESUME_FROM_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && wake_code == 2'd1) |-> ($past(mode) == 2'd2 || $past(mode) == 2'd3)); // R6

  AST_NO_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_valid |-> (wake_code == 2'd0)); // R11
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stop_req      (stop_req),
  .mask_s        (mask_s),
  .mask_i        (mask_i),
  .nocop         (nocop),
  .cpu_halt      (cpu_halt),
  .periph_clk_en (periph_clk_en),
  .osc_en        (osc_en),
  .timer_clk_en  (timer_clk_en),
  .wake_valid    (wake_valid),
  .wake_code     (wake_code),
  .mode          (mode)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int SETTLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 0, stop_req = 0, mask_s = 1, mask_x = 1, mask_i = 1, nocop = 0;
  logic dly_wr = 0, dly_wr_val = 0;
  logic irq_n = 1, xirq_n = 1, ext_reset_n = 1, irq_edge_pend = 0, int_req = 0;
  logic cpu_halt, periph_clk_en, osc_en, timer_clk_en, wake_valid, dly;
  logic [1:0] wake_code, mode;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.SETTLE_CYCLES(SETTLE)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
    .mask_s(mask_s), .mask_x(mask_x), .mask_i(mask_i), .nocop(nocop),
    .dly_wr(dly_wr), .dly_wr_val(dly_wr_val), .irq_n(irq_n), .xirq_n(xirq_n),
    .ext_reset_n(ext_reset_n), .irq_edge_pend(irq_edge_pend), .int_req(int_req),
    .cpu_halt(cpu_halt), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .timer_clk_en(timer_clk_en), .wake_valid(wake_valid), .wake_code(wake_code),
    .mode(mode), .dly(dly)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // poll for a wake strobe; counts cycles and cycles spent in SETTLE
  task automatic poll_wake(input int lim, output bit seen, output int code,
                           output int n, output int nset);
    seen = 0; code = 0; n = 0; nset = 0;
    for (int k = 0; k < lim && !seen; k++) begin
      @(posedge clk); #1;
      n++;
      if (mode == 2'd3) nset++;
      if (wake_valid) begin seen = 1; code = wake_code; end
    end
  endtask

  typedef struct packed {
    logic stop; logic s; logic x; logic i; logic nocop; logic dly;
    logic irq; logic xirq; logic rst; logic edg; logic intr;
    logic wake; logic [1:0] code; logic settle;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd2,1'b0}, // R4 irq
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0}, // R4 masked, R3 timer off
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,2'd2,1'b0}, // R4 xirq
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b1, 1'b0,2'd0,1'b0}, // R4 all masked
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,2'd2,1'b0}, // R4 internal
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,2'd3,1'b0}, // R10
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd2,1'b0}, // R5
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,2'd2,1'b1}, // R5 edge, R8
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0}, // R5 masked
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,2'd0,1'b0}, // R5 internal
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,2'd1,1'b0}, // R6 resume
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,2'd2,1'b1}, // R6 service
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,2'd1,1'b0}, // R7 xirq over irq
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1,2'd3,1'b1}, // R7 R9 reset wins
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1,2'd3,1'b0}  // R7 in wait
  };

  initial begin
    bit seen; int code, n, nset;

    // R12: state held in reset
    step(3);
    chk(mode == 2'd3, "R12 mode", mode, 3);
    chk(osc_en && cpu_halt, "R12 osc/halt", {osc_en, cpu_halt}, 3);
    chk(dly == 1'b1, "R12 dly", dly, 1);
    chk(wake_valid == 1'b0, "R12 wake", wake_valid, 0);

    // R9: power-on settle then reset code
    rst_n = 1'b1;
    poll_wake(200, seen, code, n, nset);
    chk(seen && code == 3, "R9 por code", code, 3);
    chk(n >= SETTLE, "R9 por settle", n, SETTLE);
    // R11: single-cycle strobe
    @(posedge clk); #1;
    chk(!wake_valid && wake_code == 0, "R11 strobe", {wake_valid, wake_code}, 0);
    step(2);

    // R1: stop ignored under stop mask
    mask_s = 1; stop_req = 1; step(1); stop_req = 0; step(2);
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(osc_en && periph_clk_en && timer_clk_en && !cpu_halt, "R1 clocks",
        {osc_en, periph_clk_en, timer_clk_en, cpu_halt}, 14);

    // R10 in RUN + R9 dly forced by pin
    dly_wr = 1; dly_wr_val = 0; step(1); dly_wr = 0; step(1);
    chk(dly == 1'b0, "R9 dly write", dly, 0);
    ext_reset_n = 0;
    poll_wake(20, seen, code, n, nset);
    chk(seen && code == 3 && mode == 2'd0, "R10 run reset", code, 3);
    chk(dly == 1'b1, "R9 dly forced", dly, 1);
    step(1); ext_reset_n = 1; step(5);

    // table walk
    for (int v = 0; v < NV; v++) begin
      vec_t e;
      e = VEC[v];
      dly_wr = 1; dly_wr_val = e.dly; step(1); dly_wr = 0;
      mask_s = e.s; mask_x = e.x; mask_i = e.i; nocop = e.nocop;
      if (e.stop) stop_req = 1; else wait_req = 1;
      step(1); stop_req = 0; wait_req = 0; step(1);
      if (e.stop) begin
        chk(mode == 2'd2, $sformatf("R2 v%0d mode", v), mode, 2);
        chk(!osc_en && !periph_clk_en && !timer_clk_en && cpu_halt,
            $sformatf("R2 v%0d gates", v), {osc_en, periph_clk_en, timer_clk_en, cpu_halt}, 1);
      end else begin
        chk(mode == 2'd1 && cpu_halt && osc_en && periph_clk_en,
            $sformatf("R3 v%0d wait", v), mode, 1);
        chk(timer_clk_en == !(e.i && e.nocop), $sformatf("R3 v%0d timer", v),
            timer_clk_en, !(e.i && e.nocop));
      end
      irq_n = !e.irq; xirq_n = !e.xirq; ext_reset_n = !e.rst;
      irq_edge_pend = e.edg; int_req = e.intr;
      poll_wake(e.wake ? 120 : 20, seen, code, n, nset);
      chk(seen == e.wake, $sformatf("R4 R5 v%0d wake", v), seen, e.wake);
      if (e.wake) begin
        chk(code == e.code, $sformatf("R6 R7 v%0d code", v), code, e.code);
        if (e.settle) chk(nset == SETTLE, $sformatf("R8 v%0d settle", v), nset, SETTLE);
        else          chk(nset == 0,      $sformatf("R8 v%0d nosettle", v), nset, 0);
        chk(mode == 2'd0, $sformatf("R11 v%0d run", v), mode, 0);
      end else begin
        chk(mode == (e.stop ? 2'd2 : 2'd1), $sformatf("R5 v%0d held", v), mode, e.stop ? 2 : 1);
      end
      step(1);
      irq_n = 1; xirq_n = 1; irq_edge_pend = 0; int_req = 0;
      if (!e.wake) begin
        ext_reset_n = 0;
        poll_wake(120, seen, code, n, nset);
        step(1);
      end
      ext_reset_n = 1;
      step(5);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule